// File: doc/BRIEF.md
# Effective-Address Sequencer for an 8-bit Processor

This block produces the memory read address of an operand for an 8-bit processor with a 16-bit address bus. It covers three addressing schemes. The first is indexed absolute, with either X or Y as the index. The second is zero-page indirect with X added before the pointer is read. The third is zero-page indirect with Y added after the pointer is read. The block starts from the opcode address. It fetches the operand bytes and any pointer bytes through a byte-wide read port and ends with the operand read itself. It drives a valid address on the bus in every cycle, and it drives the incoming opcode address while it waits.

The block saves cycles by adding the index to the low displacement byte while the high byte is still on its way in. When that addition stays within the page, the first operand read already hits the right location. When the addition carries, the read goes out with the high byte not yet corrected. One more cycle then raises the high byte and repeats the read. A done strobe marks the final read. A cycle counter shows how many bus cycles the access took.

Top module: `ea_sequencer`

## Requirements
- R1: While idle, `busAddr` equals `pcIn`. A cycle in which `start` is high is cycle 1, the opcode fetch at `pcIn`, and `cycCount` reads 1 in that cycle. After reset, `done` is low.
- R2: `mode` is encoded as 0 = absolute+X, 1 = absolute+Y, 2 = zero-page pre-indexed by X, 3 = zero-page post-indexed by Y. The index that the mode does not name has no effect on any bus address.
- R3: The absolute modes read the low displacement byte at pc+1 (cycle 2) and the high byte at pc+2 (cycle 3). Cycle 4 reads {high, (low+index) mod 256}. If low+index < 256 the access ends there after 4 cycles.
- R4: In the absolute modes, if low+index >= 256, cycle 4 reads the uncorrected address. Cycle 5 then reads {(high+1) mod 256, (low+index) mod 256}, and the access ends after 5 cycles.
- R5: Pre-indexed mode reads operand z at pc+1 and then performs a dummy read at {0,z}. The pointer is read from p = (z+X) mod 256 and then (p+1) mod 256. The final read goes to that pointer in cycle 6, with no fix-up cycle in any case.
- R6: Post-indexed mode reads operand z at pc+1, then the pointer at {0,z} and {0,(z+1) mod 256}. Cycle 5 reads {high, (low+Y) mod 256}. It ends there in 5 cycles when there is no carry; otherwise cycle 6 reads with the high byte plus one.
- R7: `done` is high for exactly the final read cycle. In that cycle `effAddr` equals `busAddr` and `cycCount` equals the total cycle count. The next cycle is idle again.
- R8: Every pointer and zero-page access has an upper address byte of 0. A pointer at 0xFF takes its high byte from 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an access in this idle cycle |
| mode | input | 2 | Addressing scheme, sampled with start |
| pcIn | input | 16 | Opcode address, sampled with start |
| xIdx | input | 8 | X index, sampled with start |
| yIdx | input | 8 | Y index, sampled with start |
| rdData | input | 8 | Byte read from busAddr in this cycle |
| busAddr | output | 16 | Bus address for this cycle |
| done | output | 1 | Final operand read is on the bus |
| effAddr | output | 16 | Effective address, valid with done |
| cycCount | output | 3 | Cycle number of the current access |

## Verification
The bench aims at the page-carry boundary. Index values of 0, 1, 0x7F, 0x80 and 0xFF are combined with many displacement bytes. A design that dropped the fix-up cycle would finish too early at a wrong page. A design that always inserted the fix-up cycle would report 5 or 6 cycles where 4 or 5 are due. Pointers placed at 0xFF, whether direct or reached through X, test zero-page wrap. A design that carried into page one would read the pointer high byte from 0x0100. Each access gives the unused index the complement of the used one, so picking the wrong register changes the addresses.

// File: rtl/ea_seq_pkg.sv
package ea_seq_pkg;

  typedef enum logic [1:0] {
    MODE_ABSX = 2'd0,
    MODE_ABSY = 2'd1,
    MODE_INDX = 2'd2,
    MODE_INDY = 2'd3
  } amode_e;

  typedef enum logic [2:0] {
    SEL_PC,
    SEL_OP1,
    SEL_OP2,
    SEL_ZP,
    SEL_ZP1,
    SEL_EFF,
    SEL_FIX
  } asel_e;

  typedef struct packed {
    logic  capStart;
    logic  useY;
    logic  ldZp;
    logic  addZp;
    logic  ldLo;
    logic  ldHi;
    logic  addLo;
    asel_e sel;
  } seq_ctl_t;

endpackage

// File: rtl/ea_seq_datapath.sv
module ea_seq_datapath
  import ea_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  seq_ctl_t              ctl,
  input  logic [2*DATA_W-1:0]   pcIn,
  input  logic [DATA_W-1:0]     xIdx,
  input  logic [DATA_W-1:0]     yIdx,
  input  logic [DATA_W-1:0]     rdData,
  output logic [2*DATA_W-1:0]   busAddr,
  output logic                  carry
);
  localparam int ADDR_W = 2 * DATA_W;

  logic [ADDR_W-1:0] pcReg;
  logic [DATA_W-1:0] idxReg;
  logic [DATA_W-1:0] zpReg;
  logic [DATA_W-1:0] loReg;
  logic [DATA_W-1:0] hiReg;
  logic              carryReg;
  logic [DATA_W-1:0] zpNext;
  logic [DATA_W:0]   loSum;

  assign zpNext = zpReg + DATA_W'(1);
  assign loSum  = {1'b0, loReg} + {1'b0, idxReg};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcReg    <= '0;
      idxReg   <= '0;
      zpReg    <= '0;
      loReg    <= '0;
      hiReg    <= '0;
      carryReg <= 1'b0;
    end else begin
      if (ctl.capStart) begin
        pcReg    <= pcIn;
        idxReg   <= ctl.useY ? yIdx : xIdx;
        carryReg <= 1'b0;
      end
      if (ctl.ldZp)       zpReg <= rdData;
      else if (ctl.addZp) zpReg <= zpReg + idxReg;
      if (ctl.ldLo) loReg <= rdData;
      else if (ctl.addLo) {carryReg, loReg} <= loSum;
      if (ctl.ldHi) hiReg <= rdData;
    end
  end

  always_comb begin
    case (ctl.sel)
      SEL_OP1: busAddr = pcReg + ADDR_W'(1);
      SEL_OP2: busAddr = pcReg + ADDR_W'(2);
      SEL_ZP:  busAddr = {{DATA_W{1'b0}}, zpReg};
      SEL_ZP1: busAddr = {{DATA_W{1'b0}}, zpNext};
      SEL_EFF: busAddr = {hiReg, loReg};
      SEL_FIX: busAddr = {hiReg + DATA_W'(1), loReg};
      default: busAddr = pcIn;
    endcase
  end

  assign carry = carryReg;

  // R4: the fix-up read keeps the low byte and raises the page by one
  assert_fix_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.sel == SEL_FIX) |->
      (busAddr[DATA_W-1:0] == $past(busAddr[DATA_W-1:0])) &&
      (busAddr[ADDR_W-1:DATA_W] == $past(busAddr[ADDR_W-1:DATA_W]) + DATA_W'(1)));

  // R8: pointer high byte read sits one above the low byte, wrapping in page zero
  assert_zp_wrap_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.sel == SEL_ZP1) |->
      (busAddr[DATA_W-1:0] == $past(busAddr[DATA_W-1:0]) + DATA_W'(1)) &&
      (busAddr[ADDR_W-1:DATA_W] == '0));

  // R3: the cycle after start fetches the byte following the opcode
  assert_op_follow_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.capStart && rstN) |-> busAddr == $past(pcIn) + ADDR_W'(1));

endmodule

// File: rtl/ea_seq_control.sv
module ea_seq_control
  import ea_seq_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  amode_e           mode,
  input  logic             carry,
  output seq_ctl_t         ctl,
  output logic             done,
  output logic [CNT_W-1:0] cycCount
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_OP1, ST_OP2, ST_PLO, ST_PHI, ST_READ, ST_FIX
  } state_e;

  state_e           state, stateNxt;
  amode_e           modeReg;
  logic [CNT_W-1:0] cnt;
  logic             isAbs;

  assign isAbs = (modeReg == MODE_ABSX) || (modeReg == MODE_ABSY);

  always_comb begin
    ctl      = '0;
    ctl.sel  = SEL_PC;
    done     = 1'b0;
    stateNxt = state;
    case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.capStart = 1'b1;
          ctl.useY     = (mode == MODE_ABSY) || (mode == MODE_INDY);
          stateNxt     = ST_OP1;
        end
      end
      ST_OP1: begin
        ctl.sel = SEL_OP1;
        if (isAbs) begin
          ctl.ldLo = 1'b1;
          stateNxt = ST_OP2;
        end else begin
          ctl.ldZp = 1'b1;
          stateNxt = (modeReg == MODE_INDX) ? ST_OP2 : ST_PLO;
        end
      end
      ST_OP2: begin
        if (isAbs) begin
          ctl.sel   = SEL_OP2;
          ctl.ldHi  = 1'b1;
          ctl.addLo = 1'b1;
          stateNxt  = ST_READ;
        end else begin
          ctl.sel   = SEL_ZP;
          ctl.addZp = 1'b1;
          stateNxt  = ST_PLO;
        end
      end
      ST_PLO: begin
        ctl.sel  = SEL_ZP;
        ctl.ldLo = 1'b1;
        stateNxt = ST_PHI;
      end
      ST_PHI: begin
        ctl.sel   = SEL_ZP1;
        ctl.ldHi  = 1'b1;
        ctl.addLo = (modeReg == MODE_INDY);
        stateNxt  = ST_READ;
      end
      ST_READ: begin
        ctl.sel = SEL_EFF;
        if (carry) begin
          stateNxt = ST_FIX;
        end else begin
          done     = 1'b1;
          stateNxt = ST_IDLE;
        end
      end
      ST_FIX: begin
        ctl.sel  = SEL_FIX;
        done     = 1'b1;
        stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      modeReg <= MODE_ABSX;
      cnt     <= '0;
    end else begin
      state <= stateNxt;
      if (ctl.capStart) begin
        modeReg <= mode;
        cnt     <= CNT_W'(2);
      end else if (state != ST_IDLE) begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  assign cycCount = (state == ST_IDLE) ? CNT_W'(1) : cnt;

  // R7: done lasts a single cycle
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3: indexed absolute without carry ends in cycle 4
  assert_abs_fast_R3: assert property (@(posedge clk) disable iff (!rstN)
    (done && isAbs && state == ST_READ) |-> cycCount == CNT_W'(4));

  // R4: indexed absolute with carry ends in cycle 5
  assert_abs_slow_R4: assert property (@(posedge clk) disable iff (!rstN)
    (done && isAbs && state == ST_FIX) |-> cycCount == CNT_W'(5));

  // R5: pre-indexed always ends in cycle 6 without a fix-up
  assert_indx_len_R5: assert property (@(posedge clk) disable iff (!rstN)
    (done && modeReg == MODE_INDX) |-> (cycCount == CNT_W'(6)) && (state == ST_READ));

  // R6: post-indexed ends in 5, or 6 with the fix-up
  assert_indy_len_R6: assert property (@(posedge clk) disable iff (!rstN)
    (done && modeReg == MODE_INDY) |->
      cycCount == ((state == ST_FIX) ? CNT_W'(6) : CNT_W'(5)));

endmodule

// File: rtl/ea_sequencer.sv
module ea_sequencer
  import ea_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [1:0]          mode,
  input  logic [2*DATA_W-1:0] pcIn,
  input  logic [DATA_W-1:0]   xIdx,
  input  logic [DATA_W-1:0]   yIdx,
  input  logic [DATA_W-1:0]   rdData,
  output logic [2*DATA_W-1:0] busAddr,
  output logic                done,
  output logic [2*DATA_W-1:0] effAddr,
  output logic [CNT_W-1:0]    cycCount
);
  seq_ctl_t ctl;
  logic     carry;
  amode_e   modeSel;

  assign modeSel = amode_e'(mode);

  ea_seq_control #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .mode     (modeSel),
    .carry    (carry),
    .ctl      (ctl),
    .done     (done),
    .cycCount (cycCount)
  );

  ea_seq_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .pcIn    (pcIn),
    .xIdx    (xIdx),
    .yIdx    (yIdx),
    .rdData  (rdData),
    .busAddr (busAddr),
    .carry   (carry)
  );

  assign effAddr = done ? busAddr : '0;

endmodule

// File: tb/tb_ea_sequencer.sv
module tb_ea_sequencer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [15:0] pcIn = 16'h0400;
  logic [7:0]  xIdx = 8'd0;
  logic [7:0]  yIdx = 8'd0;
  logic [7:0]  rdData;
  logic [15:0] busAddr;
  logic        done;
  logic [15:0] effAddr;
  logic [2:0]  cycCount;

  int total = 0;
  int bad = 0;

  logic        ovEn = 1'b0;
  logic [15:0] ovAddr = 16'h0;
  logic [7:0]  ovVal = 8'h0;

  always #4 clk = ~clk;

  ea_sequencer dut (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .pcIn(pcIn),
    .xIdx(xIdx), .yIdx(yIdx), .rdData(rdData), .busAddr(busAddr),
    .done(done), .effAddr(effAddr), .cycCount(cycCount)
  );

  function automatic logic [7:0] memRd(input logic [15:0] a);
    logic [7:0] t;
    if (ovEn && a == ovAddr) return ovVal;
    t = (a[7:0] * 8'd29) ^ (a[15:8] * 8'd11) ^ 8'h5a;
    return t;
  endfunction

  always_comb rdData = memRd(busAddr);

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runOp(input logic [1:0] m, input logic [15:0] pc,
                       input logic [7:0] xv, input logic [7:0] yv);
    logic [15:0] exp [0:6];
    int n;
    logic [7:0] lo, hi, zp, p, idx;
    logic [8:0] s;
    string req;
    idx = (m == 2'd1 || m == 2'd3) ? yv : xv;
    exp[0] = pc;
    exp[1] = pc + 16'd1;
    if (m < 2'd2) begin
      req = "R3/R4";
      lo = memRd(pc + 16'd1);
      hi = memRd(pc + 16'd2);
      s  = {1'b0, lo} + {1'b0, idx};
      exp[2] = pc + 16'd2;
      exp[3] = {hi, s[7:0]};
      n = 4;
      if (s[8]) begin exp[4] = {hi + 8'd1, s[7:0]}; n = 5; end
    end else if (m == 2'd2) begin
      req = "R5";
      zp = memRd(pc + 16'd1);
      p  = zp + xv;
      lo = memRd({8'h00, p});
      hi = memRd({8'h00, p + 8'd1});
      exp[2] = {8'h00, zp};
      exp[3] = {8'h00, p};
      exp[4] = {8'h00, p + 8'd1};
      exp[5] = {hi, lo};
      n = 6;
    end else begin
      req = "R6";
      zp = memRd(pc + 16'd1);
      lo = memRd({8'h00, zp});
      hi = memRd({8'h00, zp + 8'd1});
      s  = {1'b0, lo} + {1'b0, yv};
      exp[2] = {8'h00, zp};
      exp[3] = {8'h00, zp + 8'd1};
      exp[4] = {hi, s[7:0]};
      n = 5;
      if (s[8]) begin exp[5] = {hi + 8'd1, s[7:0]}; n = 6; end
    end
    @(negedge clk);
    mode = m; pcIn = pc; xIdx = xv; yIdx = yv; start = 1'b1;
    for (int k = 0; k < n; k++) begin
      if (k > 0) begin
        @(negedge clk);
        start = 1'b0;
      end
      #1;
      if (k == 0) chk(cycCount == 3'd1, "R1 opcode cycle count", cycCount, 1);
      chk(busAddr == exp[k], req, busAddr, exp[k]);
      chk(done == (k == n - 1), "R7 done timing", done, (k == n - 1));
      if (k == n - 1) begin
        chk(effAddr == exp[k], "R7 effAddr", effAddr, exp[k]);
        chk(cycCount == 3'(n), "R7 cycle total", cycCount, n);
      end
    end
    @(negedge clk);
    start = 1'b0;
    #1;
    chk(done == 1'b0 && busAddr == pcIn, "R7 idle after done", busAddr, pcIn);
  endtask

  function automatic logic [7:0] idxVal(input int j);
    case (j)
      0: return 8'h00;
      1: return 8'h01;
      2: return 8'h7f;
      3: return 8'h80;
      default: return 8'hff;
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(done == 1'b0, "R1 reset done", done, 0);
    chk(busAddr == pcIn, "R1 reset bus", busAddr, pcIn);
    chk(cycCount == 3'd1, "R1 reset count", cycCount, 1);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    chk(busAddr == pcIn && done == 1'b0, "R1 idle bus", busAddr, pcIn);

    // R2: each mode, the unused index carries the complement of the used one
    for (int m = 0; m < 4; m++)
      for (int j = 0; j < 5; j++)
        for (int i = 0; i < 41; i++) begin
          logic [15:0] pc;
          pc = (i == 40) ? 16'hfffe : 16'h0200 + 16'(i) * 16'h0137;
          runOp(2'(m), pc, idxVal(j), ~idxVal(j));
          runOp(2'(m), pc, ~idxVal(j), idxVal(j));
        end

    // R8: pointer at 0xFF through the post-index path
    ovEn = 1'b1; ovAddr = 16'h3001; ovVal = 8'hff;
    runOp(2'd3, 16'h3000, 8'h12, 8'h34);
    runOp(2'd3, 16'h3000, 8'h00, 8'hff);
    // R8: X pre-index wraps to 0xFF and the high byte comes from 0x00
    ovVal = 8'hf0;
    runOp(2'd2, 16'h3000, 8'h0f, 8'h00);
    runOp(2'd2, 16'h3000, 8'h20, 8'h00);
    ovEn = 1'b0;

    // R4: explicit carry from 0xFF displacement low byte
    ovEn = 1'b1; ovAddr = 16'h5001; ovVal = 8'hff;
    runOp(2'd0, 16'h5000, 8'h01, 8'h00);
    runOp(2'd1, 16'h5000, 8'h00, 8'h00);
    ovEn = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule